// File: doc/BRIEF.md
# Reloading overflow timer with posted register writes

This block is a 32-bit up-counter peripheral driven through a plain register bus (word address, write data, write strobe, read strobe, read data). While its start bit is set, the counter advances by one on every cycle where the functional tick enable is high. When the count passes all ones, an overflow flag is raised and the counter either restarts from a programmed load value or wraps to zero. Software gets a periodic interrupt every N ticks by writing `0xFFFFFFFF - (N - 1)` into both the load and the count registers and setting start and autoreload.

The control, count and load registers can be written in posted mode. A posted write is accepted at once, takes effect a fixed delay later, and raises a per-register busy bit that software polls before its next access. Posted mode can be switched off through an interface register, and the whole timer can be returned to its defaults with a self-clearing soft-reset bit. Interrupt enables are changed only through separate set and clear registers. The level interrupt output stays high while any enabled status flag is set.

Top module: `ovf_timer`

## Requirements
- R1: After reset, the control, count, load, status and enable registers read 0, the pending register reads 0, the soft-reset bit reads 0, the posted-mode bit reads 1 and `irq` is low.
- R2: With control bit 0 (start) set, the count rises by one on each cycle with `tick` high. With start clear, ticks leave the count unchanged.
- R3: On a tick at count 0xFFFFFFFF, status bit 0 is set and the counter loads the load register if control bit 1 (autoreload) is set, or 0 if it is clear. With load = count = 0xFFFFFFFF-(N-1), overflow occurs on every Nth tick.
- R4: Writing the status register (address 2) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R5: Writing 1s to address 3 sets enable bits and writing 1s to address 4 clears them. Bits written as 0 are unaffected, and both addresses read back the current enables.
- R6: `irq` is high exactly while some status bit and its enable bit are both 1, and it stays high until the flag is cleared or the enable is removed.
- R7: With posted mode on, a write to control (5), count (6) or load (7) changes the register 4 cycles after the write is accepted. The pending register (8) holds bit 0 for control, bit 1 for count and bit 2 for load, and each bit is 1 from acceptance until the write takes effect.
- R8: With interface register (1) bit 0 written as 0, writes to control, count and load take effect on the next cycle and the pending register reads 0.
- R9: Writing 1 to bit 0 of the configuration register (0) starts a soft reset. That bit reads 1 for 8 cycles and then 0, and afterwards every register is at its R1 value, including posted mode back at 1.
- R10: Reads are returned on `rdata` in the cycle after the read strobe. The count register can be read at any time and can be written to preset the count. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe |
| tick | input | 1 | Functional-clock count enable |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that software does not rewrite a posted register while its pending bit is still set, and that writes issued during a soft reset are meant to be dropped. The stimulus keeps to this by reading the pending register, or waiting out the known delay, before it touches the same register again. It leaves the bus idle during the soft-reset window except for polling reads. It also holds `tick` low during register writes, so that a count preset and a count step never meet in the same cycle.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_CFG   = 4'd0,
    RA_IFC   = 4'd1,
    RA_STAT  = 4'd2,
    RA_ENSET = 4'd3,
    RA_ENCLR = 4'd4,
    RA_CTRL  = 4'd5,
    RA_COUNT = 4'd6,
    RA_LOAD  = 4'd7,
    RA_PEND  = 4'd8
  } reg_addr_e;

  // index of each posted register inside the pending vector
  localparam int PI_CTRL  = 0;
  localparam int PI_COUNT = 1;
  localparam int PI_LOAD  = 2;
  localparam int NPOST    = 3;

  // control field positions
  localparam int CB_START = 0;
  localparam int CB_AUTO  = 1;
  localparam int CTRL_W   = 2;

  // number of interrupt sources (overflow only)
  localparam int NSRC = 1;
endpackage

// File: rtl/ovf_timer_post.sv
module ovf_timer_post
  import ovf_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCH    = NPOST,
  parameter int DELAY  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        posted,
  input  logic [NCH-1:0]              sel,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NCH-1:0]              apply,
  output logic [NCH-1:0][DATA_W-1:0]  adata,
  output logic [NCH-1:0]              pend
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DELAY - 1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic              pend_q, pend_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [DATA_W-1:0] dat_q, dat_d;
    logic              dat_en;
    logic              direct;
    logic              expire;

    assign direct = sel[g] && !posted;
    assign expire = pend_q && (cnt_q == '0);
    assign dat_en = sel[g] && posted && !clear;

    always_comb begin
      pend_d = pend_q;
      cnt_d  = cnt_q;
      dat_d  = dat_q;
      if (clear) begin
        pend_d = 1'b0;
        cnt_d  = '0;
      end else if (sel[g] && posted) begin
        pend_d = 1'b1;
        cnt_d  = RELOAD;
        dat_d  = wdata;
      end else if (pend_q) begin
        if (cnt_q == '0) pend_d = 1'b0;
        else             cnt_d  = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        pend_q <= pend_d;
        cnt_q  <= cnt_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dat_q <= '0;
      else if (dat_en) dat_q <= dat_d;
    end

    assign apply[g] = !clear && (direct || expire);
    assign adata[g] = direct ? wdata : dat_q;
    assign pend[g]  = pend_q;
  end
endmodule

// File: rtl/ovf_timer_count.sv
module ovf_timer_count
  import ovf_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  logic [NPOST-1:0]  apply,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic [DATA_W-1:0] count_data,
  input  logic [DATA_W-1:0] load_data,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] load,
  output logic              ovf
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] count_q, count_d;
  logic [DATA_W-1:0] load_q, load_d;
  logic              step;

  assign step = ctrl_q[CB_START] && tick;

  always_comb begin
    ctrl_d  = ctrl_q;
    load_d  = load_q;
    count_d = count_q;
    ovf     = 1'b0;
    if (apply[PI_CTRL]) ctrl_d = ctrl_data;
    if (apply[PI_LOAD]) load_d = load_data;
    if (apply[PI_COUNT]) begin
      count_d = count_data;
    end else if (step) begin
      if (&count_q) begin
        ovf     = 1'b1;
        count_d = ctrl_q[CB_AUTO] ? load_q : '0;
      end else begin
        count_d = count_q + 1'b1;
      end
    end
    if (clear) begin
      ctrl_d  = '0;
      load_d  = '0;
      count_d = '0;
      ovf     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      count_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      load_q  <= load_d;
      count_q <= count_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign count = count_q;
  assign load  = load_q;
endmodule

// File: rtl/ovf_timer_irq.sv
module ovf_timer_irq #(
  parameter int NS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [NS-1:0] src,
  input  logic          stat_wr,
  input  logic          set_wr,
  input  logic          clr_wr,
  input  logic [NS-1:0] wmask,
  output logic [NS-1:0] stat,
  output logic [NS-1:0] en,
  output logic          irq
);
  logic [NS-1:0] stat_q, stat_d;
  logic [NS-1:0] en_q, en_d;
  logic [NS-1:0] w1c, w1s, w1e;

  assign w1c = stat_wr ? wmask : '0;
  assign w1s = set_wr  ? wmask : '0;
  assign w1e = clr_wr  ? wmask : '0;

  always_comb begin
    stat_d = (stat_q & ~w1c) | src;
    en_d   = (en_q | w1s) & ~w1e;
    if (clear) begin
      stat_d = '0;
      en_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  assign stat = stat_q;
  assign en   = en_q;
  assign irq  = |(stat_q & en_q);
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = REG_AW,
  parameter int POST_DLY = 4,
  parameter int SRST_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              tick,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int SCW = $clog2(SRST_CYC + 1);
  localparam logic [SCW-1:0] SRST_LOAD = SCW'(SRST_CYC);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] sync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_ns = sync_q[1];

  // address decode
  logic hit_cfg, hit_ifc, hit_stat, hit_enset, hit_enclr;
  logic hit_ctrl, hit_count, hit_load, hit_pend;
  assign hit_cfg   = (addr == ADDR_W'(RA_CFG));
  assign hit_ifc   = (addr == ADDR_W'(RA_IFC));
  assign hit_stat  = (addr == ADDR_W'(RA_STAT));
  assign hit_enset = (addr == ADDR_W'(RA_ENSET));
  assign hit_enclr = (addr == ADDR_W'(RA_ENCLR));
  assign hit_ctrl  = (addr == ADDR_W'(RA_CTRL));
  assign hit_count = (addr == ADDR_W'(RA_COUNT));
  assign hit_load  = (addr == ADDR_W'(RA_LOAD));
  assign hit_pend  = (addr == ADDR_W'(RA_PEND));

  // soft reset sequencer
  logic [SCW-1:0] srst_q, srst_d;
  logic           busy;
  assign busy = (srst_q != '0);

  always_comb begin
    srst_d = srst_q;
    if (busy)                             srst_d = srst_q - 1'b1;
    else if (wr && hit_cfg && wdata[0])   srst_d = SRST_LOAD;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) srst_q <= '0;
    else         srst_q <= srst_d;
  end

  // posted-mode bit
  logic posted_q, posted_d;
  always_comb begin
    posted_d = posted_q;
    if (busy)               posted_d = 1'b1;
    else if (wr && hit_ifc) posted_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) posted_q <= 1'b1;
    else         posted_q <= posted_d;
  end

  // write strobes into the timer registers
  logic             wr_ok;
  logic [NPOST-1:0] post_sel;
  logic             stat_wr, set_wr, clr_wr;
  logic             stat_clr_hit;
  assign wr_ok             = wr && !busy;
  assign post_sel[PI_CTRL]  = wr_ok && hit_ctrl;
  assign post_sel[PI_COUNT] = wr_ok && hit_count;
  assign post_sel[PI_LOAD]  = wr_ok && hit_load;
  assign stat_wr           = wr_ok && hit_stat;
  assign set_wr            = wr_ok && hit_enset;
  assign clr_wr            = wr_ok && hit_enclr;
  assign stat_clr_hit      = stat_wr && wdata[0];

  logic [NPOST-1:0]             apply_vec;
  logic [NPOST-1:0][DATA_W-1:0] adata;
  logic [NPOST-1:0]             pend_raw;

  ovf_timer_post #(
    .DATA_W (DATA_W),
    .NCH    (NPOST),
    .DELAY  (POST_DLY)
  ) u_post (
    .clk    (clk),
    .rst_n  (rst_ns),
    .clear  (busy),
    .posted (posted_q),
    .sel    (post_sel),
    .wdata  (wdata),
    .apply  (apply_vec),
    .adata  (adata),
    .pend   (pend_raw)
  );

  logic [CTRL_W-1:0] ctrl_wdata;
  logic [DATA_W-1:0] count_wdata, load_wdata;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] count_q, load_q;
  logic              ovf_pulse;
  assign ctrl_wdata  = adata[PI_CTRL][CTRL_W-1:0];
  assign count_wdata = adata[PI_COUNT];
  assign load_wdata  = adata[PI_LOAD];

  ovf_timer_count #(
    .DATA_W (DATA_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_ns),
    .clear      (busy),
    .tick       (tick),
    .apply      (apply_vec),
    .ctrl_data  (ctrl_wdata),
    .count_data (count_wdata),
    .load_data  (load_wdata),
    .ctrl       (ctrl_q),
    .count      (count_q),
    .load       (load_q),
    .ovf        (ovf_pulse)
  );

  logic [NSRC-1:0] stat_q, en_q;

  ovf_timer_irq #(
    .NS (NSRC)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .clear   (busy),
    .src     (ovf_pulse),
    .stat_wr (stat_wr),
    .set_wr  (set_wr),
    .clr_wr  (clr_wr),
    .wmask   (wdata[NSRC-1:0]),
    .stat    (stat_q),
    .en      (en_q),
    .irq     (irq)
  );

  // read path
  logic [NPOST-1:0]  pend_rd;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  assign pend_rd = posted_q ? pend_raw : '0;

  always_comb begin
    rdata_d = '0;
    if (hit_cfg)   rdata_d = DATA_W'(busy);
    if (hit_ifc)   rdata_d = DATA_W'(posted_q);
    if (hit_stat)  rdata_d = DATA_W'(stat_q);
    if (hit_enset || hit_enclr) rdata_d = DATA_W'(en_q);
    if (hit_ctrl)  rdata_d = DATA_W'(ctrl_q);
    if (hit_count) rdata_d = count_q;
    if (hit_load)  rdata_d = load_q;
    if (hit_pend)  rdata_d = DATA_W'(pend_rd);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk
  import ovf_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              posted,
  input logic [CTRL_W-1:0] ctrl,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] load,
  input logic [NSRC-1:0]   stat,
  input logic [NSRC-1:0]   en,
  input logic [NPOST-1:0]  pend,
  input logic [NPOST-1:0]  apply,
  input logic [DATA_W-1:0] count_wdata,
  input logic              ovf,
  input logic              stat_clr_hit
);
  // R2: a stopped counter with no preset and no soft reset holds its value
  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[CB_START] && !apply[PI_COUNT] && !busy) |=> $stable(count));

  // R3: an overflow raises the status flag on the following cycle
  assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> stat[0]);

  // R4: the flag only drops after a write-one-to-clear or a soft reset
  assert_flag_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[0]) |-> $past(stat_clr_hit || busy));

  // R7: a write that takes effect lands its data in the counter
  assert_preset_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apply[PI_COUNT] && !busy) |=> (count == $past(count_wdata)));

  // R9: each soft-reset cycle leaves every register at its default
  assert_srst_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (ctrl == '0 && count == '0 && load == '0 && stat == '0 &&
              en == '0 && pend == '0 && posted));
endmodule

bind ovf_timer ovf_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_ns),
  .busy         (busy),
  .posted       (posted_q),
  .ctrl         (ctrl_q),
  .count        (count_q),
  .load         (load_q),
  .stat         (stat_q),
  .en           (en_q),
  .pend         (pend_raw),
  .apply        (apply_vec),
  .count_wdata  (count_wdata),
  .ovf          (ovf_pulse),
  .stat_clr_hit (stat_clr_hit)
);

// File: tb/ovf_timer_bench.sv
module ovf_timer_bench;
  logic        clk;
  logic        rst_n;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic        wr, rd, tick;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;

  ovf_timer u_ovf_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wdata (wdata),
    .wr    (wr),
    .rd    (rd),
    .tick  (tick),
    .rdata (rdata),
    .irq   (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam logic [3:0] A_CFG = 4'd0, A_IFC = 4'd1, A_STAT = 4'd2,
    A_ENSET = 4'd3, A_ENCLR = 4'd4, A_CTRL = 4'd5, A_COUNT = 4'd6,
    A_LOAD = 4'd7, A_PEND = 4'd8;
  localparam logic [1:0] OW = 2'd1, OR = 2'd2;

  // {op, address, data or expected value}; posted mode is turned off first
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {OW, A_IFC,   32'h0000_0000},
    {OR, A_IFC,   32'h0000_0000},
    {OW, A_LOAD,  32'hA5A5_0001},
    {OR, A_LOAD,  32'hA5A5_0001},
    {OW, A_COUNT, 32'h0000_1000},
    {OR, A_PEND,  32'h0000_0000},
    {OR, A_COUNT, 32'h0000_1000},
    {OW, A_CTRL,  32'h0000_0002},
    {OR, A_CTRL,  32'h0000_0002},
    {OW, A_ENSET, 32'h0000_0001},
    {OR, A_ENCLR, 32'h0000_0001},
    {OW, A_ENCLR, 32'h0000_0001},
    {OR, A_ENSET, 32'h0000_0000},
    {OR, A_STAT,  32'h0000_0000},
    {OR, 4'd12,   32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = 1'b0; rd = 1'b0; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    tick = 1'b0; wr = 1'b0; rd = 1'b1; addr = a;
    @(posedge clk);
    #1;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr = 1'b0; rd = 1'b0; tick = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; tick = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    bus_read(A_IFC, v);   check("R1 posted bit", v, 32'h1);
    bus_read(A_PEND, v);  check("R1 pending", v, 32'h0);
    bus_read(A_CTRL, v);  check("R1 control", v, 32'h0);
    bus_read(A_COUNT, v); check("R1 count", v, 32'h0);
    bus_read(A_CFG, v);   check("R1 soft reset bit", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // table walk: direct writes, readback, enables, idle address
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37:36] == OW) begin
        bus_write(VEC[i][35:32], VEC[i][31:0]);
      end else begin
        bus_read(VEC[i][35:32], v);
        check($sformatf("R5/R8/R10 vector %0d", i), v, VEC[i][31:0]);
      end
    end

    // R2 stopped counter ignores ticks, running counter steps
    ticks(3);
    bus_read(A_COUNT, v); check("R2 stopped", v, 32'h0000_1000);
    bus_write(A_CTRL, 32'h3);
    ticks(5);
    bus_read(A_COUNT, v); check("R2 running", v, 32'h0000_1005);

    // R3 R6 period of 5 ticks with autoreload
    bus_write(A_LOAD, 32'hFFFF_FFFB);
    bus_write(A_COUNT, 32'hFFFF_FFFB);
    bus_write(A_ENSET, 32'h1);
    ticks(4);
    check("R6 irq before overflow", {31'h0, irq}, 32'h0);
    bus_read(A_STAT, v); check("R3 no flag yet", v, 32'h0);
    ticks(1);
    check("R6 irq on overflow", {31'h0, irq}, 32'h1);
    bus_read(A_COUNT, v); check("R3 reloaded", v, 32'hFFFF_FFFB);
    bus_read(A_STAT, v);  check("R3 flag set", v, 32'h1);
    ticks(5);
    bus_read(A_COUNT, v); check("R3 second period", v, 32'hFFFF_FFFB);

    // R4 write-one-to-clear
    bus_write(A_STAT, 32'h0);
    check("R4 zero write keeps flag", {31'h0, irq}, 32'h1);
    bus_write(A_STAT, 32'h1);
    check("R4 one write clears", {31'h0, irq}, 32'h0);
    bus_read(A_STAT, v); check("R4 status cleared", v, 32'h0);

    // R5 R6 enable clear masks the output, set unmasks
    bus_write(A_ENCLR, 32'h1);
    ticks(5);
    bus_read(A_STAT, v); check("R5 flag while masked", v, 32'h1);
    check("R6 masked irq", {31'h0, irq}, 32'h0);
    bus_write(A_ENSET, 32'h1);
    check("R5 enable set raises irq", {31'h0, irq}, 32'h1);
    bus_write(A_STAT, 32'h1);
    check("R6 irq dropped", {31'h0, irq}, 32'h0);

    // R3 wrap to zero without autoreload
    bus_write(A_CTRL, 32'h0);
    bus_write(A_LOAD, 32'h0000_1234);
    bus_write(A_COUNT, 32'hFFFF_FFFE);
    bus_write(A_CTRL, 32'h1);
    ticks(2);
    bus_read(A_COUNT, v); check("R3 wrap to zero", v, 32'h0);
    bus_read(A_STAT, v);  check("R3 flag on wrap", v, 32'h1);
    ticks(1);
    bus_read(A_COUNT, v); check("R2 count after wrap", v, 32'h1);
    bus_write(A_STAT, 32'h1);
    bus_write(A_CTRL, 32'h0);

    // R7 posted count write lands four cycles after acceptance
    bus_write(A_IFC, 32'h1);
    bus_write(A_COUNT, 32'h0000_0077);
    bus_read(A_COUNT, v); check("R7 old count while pending", v, 32'h1);
    for (int k = 0; k < 3; k++) begin
      bus_read(A_PEND, v); check("R7 count pending", v, 32'h2);
    end
    bus_read(A_PEND, v);  check("R7 pending cleared", v, 32'h0);
    bus_read(A_COUNT, v); check("R7 posted count", v, 32'h0000_0077);

    // R7 overlapping control and load writes
    bus_write(A_CTRL, 32'h2);
    bus_write(A_LOAD, 32'h0000_CAFE);
    for (int k = 0; k < 5; k++) begin
      logic [31:0] e;
      e = (k < 3) ? 32'h5 : ((k == 3) ? 32'h4 : 32'h0);
      bus_read(A_PEND, v); check($sformatf("R7 pending step %0d", k), v, e);
    end
    bus_read(A_CTRL, v); check("R7 posted control", v, 32'h2);
    bus_read(A_LOAD, v); check("R7 posted load", v, 32'h0000_CAFE);

    // R9 soft reset
    bus_write(A_ENSET, 32'h1);
    bus_write(A_IFC, 32'h0);
    bus_write(A_CFG, 32'h1);
    for (int k = 0; k < 8; k++) begin
      bus_read(A_CFG, v); check($sformatf("R9 busy cycle %0d", k), v, 32'h1);
    end
    bus_read(A_CFG, v);   check("R9 self cleared", v, 32'h0);
    bus_read(A_IFC, v);   check("R9 posted restored", v, 32'h1);
    bus_read(A_LOAD, v);  check("R9 load default", v, 32'h0);
    bus_read(A_CTRL, v);  check("R9 control default", v, 32'h0);
    bus_read(A_ENSET, v); check("R9 enable default", v, 32'h0);
    bus_read(A_COUNT, v); check("R9 count default", v, 32'h0);

    @(negedge clk);
    rd = 1'b0;
    summary();
    $finish;
  end
endmodule